// File: doc/BRIEF.md
# Critical-First Burst Beat Sequencer

This block steps one data tenure across a 64-bit data path, built from a high and a low 32-bit half. On a start pulse it reads the request attributes and chooses between two transfers. A single beat moves one to eight bytes inside one double word. A burst moves a whole aligned 32-byte line. A burst is chosen only for cacheable loads and for cacheable stores marked write-back. A burst takes four double-word beats on the full-width bus, or eight word beats when the bus runs in 32-bit mode.

A burst opens with the beat that holds the critical data. Each later beat is one beat width further on and wraps inside the 32-byte line. The sequencer moves to the next beat only when that beat's data acknowledge arrives. It reports the beat number, the beat address and the byte-lane enables, and it drives a burst indicator while beats are active. It pulses done once after the final beat. It pulses an error instead of starting when a single-beat request is malformed.

The controller is a four-state machine:
- SEQ_IDLE waits for start.
- SEQ_BEAT presents the current beat.
- SEQ_END asserts done.
- SEQ_FAULT asserts the error.

Its transitions are:
- launch: SEQ_IDLE to SEQ_BEAT, on start with a valid request.
- reject: SEQ_IDLE to SEQ_FAULT, on start with a malformed request.
- hold: SEQ_BEAT to SEQ_BEAT, when no acknowledge arrives.
- step: SEQ_BEAT to SEQ_BEAT, on acknowledge of a beat that is not the last.
- finish: SEQ_BEAT to SEQ_END, on acknowledge of the last beat.
- retire: SEQ_END to SEQ_IDLE.
- recover: SEQ_FAULT to SEQ_IDLE.

Top module: `burst_beat_seq`

## Requirements
- R1: After reset the block is idle: beat_valid, done, err and burst are 0, and byte_en is 8'h00.
- R2: A burst is issued if and only if cacheable=1 and either is_store=0 or write_back=1. While beats of a burst are presented, burst=1. A single beat presents burst=0.
- R3: A burst has 4 beats when narrow_bus=0 and 8 beats when narrow_bus=1. A single-beat transfer has exactly 1 beat. beat_idx counts from 0 up to the beat count minus 1.
- R4: The first burst beat address is start_addr with its low 3 bits cleared (narrow_bus=0) or its low 2 bits cleared (narrow_bus=1). Bits 31..5 of start_addr are kept on every beat.
- R5: Each following burst beat address adds 8 (wide) or 4 (narrow) to address bits 4..0, modulo 32. For example, a wide start in double word 2 gives the double-word order 2,3,0,1.
- R6: While data_ack is 0, the presented beat (beat_valid, beat_addr, beat_idx) holds unchanged.
- R7: done is 1 for exactly one cycle, in the cycle after the clock edge that samples data_ack on the final beat. beat_valid is 0 in that cycle.
- R8: A single beat presents beat_addr equal to start_addr. Its byte_en bit i (the byte at offset i in the double word) is set exactly when start_addr[2:0] <= i < start_addr[2:0] + xfer_size.
- R9: The byte enables of a burst beat are 8'hFF in wide mode. In narrow mode they are 8'h0F when beat_addr[2]=0 and 8'hF0 when beat_addr[2]=1.
- R10: A single-beat request with xfer_size 0, or with start_addr[2:0] + xfer_size > 8, produces err=1 for one cycle and no beat and no done.
- R11: start is ignored while a transfer is in progress: the presented beat is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| start_addr | input | 32 | Byte address of the critical data |
| xfer_size | input | 4 | Single-beat byte count, 1 to 8 |
| cacheable | input | 1 | Access is cacheable |
| write_back | input | 1 | Store target is write-back |
| is_store | input | 1 | 1 for a store, 0 for a load |
| narrow_bus | input | 1 | 32-bit bus mode |
| data_ack | input | 1 | Acknowledge for the presented beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_idx | output | 3 | Number of the presented beat |
| beat_addr | output | 32 | Address of the presented beat |
| byte_en | output | 8 | Byte-lane enables, bit i = byte offset i |
| burst | output | 1 | Presented transfer is a burst |
| done | output | 1 | One-cycle pulse after the final beat |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8-byte double words, 4-byte words and a 32-byte line. With these values a wide burst is four beats and a narrow burst is eight, so every wrap position of the line can be reached from a start in mid-line. Single-beat windows can be placed against the double-word edge in both directions, which is where rejection begins.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BEAT  = 2'd1,
        SEQ_END   = 2'd2,
        SEQ_FAULT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bbs_request_decode.sv
module bbs_request_decode #(
    parameter int DW_BYTES   = 8,
    parameter int WORD_BYTES = 4,
    parameter int LINE_BYTES = 32,
    parameter int LANE_W     = $clog2(DW_BYTES),
    parameter int LINE_W     = $clog2(LINE_BYTES),
    parameter int SZ_W       = LANE_W + 1,
    parameter int IDX_W      = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic [LINE_W-1:0]   low_addr,
    input  logic [SZ_W-1:0]     size,
    input  logic                cacheable,
    input  logic                write_back,
    input  logic                is_store,
    input  logic                narrow,
    output logic                use_burst,
    output logic [LINE_W-1:0]   first_off,
    output logic [IDX_W-1:0]    last_idx,
    output logic [DW_BYTES-1:0] single_mask,
    output logic                bad
);

    localparam int WORD_W       = $clog2(WORD_BYTES);
    localparam int WIDE_BEATS   = LINE_BYTES / DW_BYTES;
    localparam int NARROW_BEATS = LINE_BYTES / WORD_BYTES;

    logic [LANE_W-1:0] lane_off;
    logic [SZ_W:0]     span;

    assign lane_off = low_addr[LANE_W-1:0];
    assign span     = {{(SZ_W+1-LANE_W){1'b0}}, lane_off} + {1'b0, size};

    // burst eligibility: cacheable, and stores must be write-back
    assign use_burst = cacheable && (!is_store || write_back);

    always_comb begin
        if (!use_burst) begin
            first_off = low_addr;
        end else if (narrow) begin
            first_off = {low_addr[LINE_W-1:WORD_W], {WORD_W{1'b0}}};
        end else begin
            first_off = {low_addr[LINE_W-1:LANE_W], {LANE_W{1'b0}}};
        end
    end

    always_comb begin
        if (!use_burst) begin
            last_idx = '0;
        end else if (narrow) begin
            last_idx = IDX_W'(NARROW_BEATS - 1);
        end else begin
            last_idx = IDX_W'(WIDE_BEATS - 1);
        end
    end

    always_comb begin
        for (int i = 0; i < DW_BYTES; i++) begin
            single_mask[i] = (i >= int'(lane_off)) && (i < int'(span));
        end
    end

    assign bad = !use_burst &&
                 ((size == '0) || (span > (SZ_W+1)'(DW_BYTES)));

endmodule

// File: rtl/bbs_beat_counter.sv
module bbs_beat_counter #(
    parameter int LINE_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [LINE_W-1:0] load_off,
    input  logic [LINE_W-1:0] step,
    output logic [LINE_W-1:0] off,
    output logic [IDX_W-1:0]  idx
);

    // offset wraps naturally inside the line because it is LINE_W bits wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off <= '0;
            idx <= '0;
        end else if (load) begin
            off <= load_off;
            idx <= '0;
        end else if (adv) begin
            off <= off + step;
            idx <= idx + 1'b1;
        end
    end

    assert_idx_steps_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
    import bbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bad,
    input  logic data_ack,
    input  logic is_last,
    output logic load,
    output logic adv,
    output logic beat_valid,
    output logic done,
    output logic err
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    state_d = bad ? SEQ_FAULT : SEQ_BEAT;
                end
            end
            SEQ_BEAT: begin
                if (data_ack && is_last) begin
                    state_d = SEQ_END;
                end
            end
            SEQ_END:   state_d = SEQ_IDLE;
            SEQ_FAULT: state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        adv        = 1'b0;
        beat_valid = 1'b0;
        done       = 1'b0;
        err        = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  load = start && !bad;
            SEQ_BEAT: begin
                beat_valid = 1'b1;
                adv        = data_ack && !is_last;
            end
            SEQ_END:   done = 1'b1;
            SEQ_FAULT: err  = 1'b1;
            default: ;
        endcase
    end

    assert_hold_without_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BEAT && !data_ack) |=> (state_q == SEQ_BEAT));

    assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !beat_valid && !done));

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
    parameter int ADDR_W     = 32,
    parameter int DW_BYTES   = 8,
    parameter int WORD_BYTES = 4,
    parameter int LINE_BYTES = 32,
    parameter int SZ_W       = $clog2(DW_BYTES) + 1,
    parameter int IDX_W      = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [SZ_W-1:0]     xfer_size,
    input  logic                cacheable,
    input  logic                write_back,
    input  logic                is_store,
    input  logic                narrow_bus,
    input  logic                data_ack,
    output logic                beat_valid,
    output logic [IDX_W-1:0]    beat_idx,
    output logic [ADDR_W-1:0]   beat_addr,
    output logic [DW_BYTES-1:0] byte_en,
    output logic                burst,
    output logic                done,
    output logic                err
);

    localparam int LANE_W = $clog2(DW_BYTES);
    localparam int WORD_W = $clog2(WORD_BYTES);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam logic [DW_BYTES-1:0] WORD_ONES = DW_BYTES'((1 << WORD_BYTES) - 1);

    logic                use_burst_w, bad_w, load_w, adv_w, is_last_w;
    logic [LINE_W-1:0]   first_off_w, off_w, step_w;
    logic [IDX_W-1:0]    last_idx_w;
    logic [DW_BYTES-1:0] single_mask_w;

    logic [ADDR_W-1:LINE_W] base_q;
    logic                   burst_q, narrow_q;
    logic [IDX_W-1:0]       last_q;
    logic [DW_BYTES-1:0]    mask_q;

    bbs_request_decode #(
        .DW_BYTES  (DW_BYTES),
        .WORD_BYTES(WORD_BYTES),
        .LINE_BYTES(LINE_BYTES),
        .LANE_W    (LANE_W),
        .LINE_W    (LINE_W),
        .SZ_W      (SZ_W),
        .IDX_W     (IDX_W)
    ) u_decode (
        .low_addr   (start_addr[LINE_W-1:0]),
        .size       (xfer_size),
        .cacheable  (cacheable),
        .write_back (write_back),
        .is_store   (is_store),
        .narrow     (narrow_bus),
        .use_burst  (use_burst_w),
        .first_off  (first_off_w),
        .last_idx   (last_idx_w),
        .single_mask(single_mask_w),
        .bad        (bad_w)
    );

    // request attributes held for the whole tenure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            burst_q  <= 1'b0;
            narrow_q <= 1'b0;
            last_q   <= '0;
            mask_q   <= '0;
        end else if (load_w) begin
            base_q   <= start_addr[ADDR_W-1:LINE_W];
            burst_q  <= use_burst_w;
            narrow_q <= narrow_bus;
            last_q   <= last_idx_w;
            mask_q   <= single_mask_w;
        end
    end

    assign step_w = narrow_q ? LINE_W'(WORD_BYTES) : LINE_W'(DW_BYTES);

    bbs_beat_counter #(
        .LINE_W(LINE_W),
        .IDX_W (IDX_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .adv     (adv_w),
        .load_off(first_off_w),
        .step    (step_w),
        .off     (off_w),
        .idx     (beat_idx)
    );

    assign is_last_w = (beat_idx == last_q);

    bbs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bad       (bad_w),
        .data_ack  (data_ack),
        .is_last   (is_last_w),
        .load      (load_w),
        .adv       (adv_w),
        .beat_valid(beat_valid),
        .done      (done),
        .err       (err)
    );

    assign beat_addr = {base_q, off_w};
    assign burst     = beat_valid && burst_q;

    always_comb begin
        if (!beat_valid) begin
            byte_en = '0;
        end else if (!burst_q) begin
            byte_en = mask_q;
        end else if (narrow_q) begin
            byte_en = WORD_ONES << {off_w[LANE_W-1:WORD_W], {WORD_W{1'b0}}};
        end else begin
            byte_en = '1;
        end
    end

    assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_ack && burst && !is_last_w) |=>
        (beat_addr[LINE_W-1:0] == $past(beat_addr[LINE_W-1:0]) + step_w));

    assert_line_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_ack && !is_last_w) |=>
        (beat_valid && beat_addr[ADDR_W-1:LINE_W] == $past(beat_addr[ADDR_W-1:LINE_W])));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !data_ack && start) |=> $stable(beat_addr) && $stable(beat_idx));

    assert_single_has_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !burst) |-> (byte_en != '0));

endmodule

// File: tb/burst_beat_seq_tb.sv
module burst_beat_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [3:0]  xfer_size = '0;
    logic        cacheable = 1'b0;
    logic        write_back = 1'b0;
    logic        is_store = 1'b0;
    logic        narrow_bus = 1'b0;
    logic        data_ack = 1'b0;
    logic        beat_valid, burst, done, err;
    logic [2:0]  beat_idx;
    logic [31:0] beat_addr;
    logic [7:0]  byte_en;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    burst_beat_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .xfer_size(xfer_size), .cacheable(cacheable), .write_back(write_back),
        .is_store(is_store), .narrow_bus(narrow_bus), .data_ack(data_ack),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .beat_addr(beat_addr),
        .byte_en(byte_en), .burst(burst), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [3:0] sz, input bit c,
                         input bit st, input bit wb, input bit nar);
        @(negedge clk);
        start = 1'b1; start_addr = a; xfer_size = sz;
        cacheable = c; is_store = st; write_back = wb; narrow_bus = nar;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!beat_valid && !done && !err && !burst, "R1 idle flags", {beat_valid, done, err, burst}, 0);
        check(byte_en == 8'h00, "R1 byte_en", byte_en, 0);
    endtask

    // burst with generic expected order; stalls on beat 1
    task automatic t_burst(input logic [31:0] a, input bit st, input bit nar);
        int n = nar ? 8 : 4;
        int step = nar ? 4 : 8;
        logic [31:0] base = a & ~32'd31;
        logic [31:0] off = (a & 32'd31) & (nar ? ~32'd3 : ~32'd7);
        issue(a, 4'd0, 1'b1, st, 1'b1, nar);
        for (int i = 0; i < n; i++) begin
            logic [31:0] ea = base | ((off + step * i) & 32'd31);
            logic [7:0]  eb = nar ? (ea[2] ? 8'hF0 : 8'h0F) : 8'hFF;
            check(beat_valid && burst, "R2 burst flag", {beat_valid, burst}, 3);
            check(beat_idx == 3'(i), "R3 beat index", beat_idx, i);
            if (i == 0) check(beat_addr == ea, "R4 first address", beat_addr, ea);
            else        check(beat_addr == ea, "R5 wrap address", beat_addr, ea);
            check(byte_en == eb, "R9 burst lanes", byte_en, eb);
            if (i == 1) begin
                data_ack = 1'b0;
                @(negedge clk); @(negedge clk);
                check(beat_valid && beat_addr == ea && beat_idx == 3'(i),
                      "R6 hold without ack", beat_addr, ea);
            end
            data_ack = 1'b1;
            @(negedge clk);
            data_ack = 1'b0;
        end
        check(done && !beat_valid, "R7 done after last", {done, beat_valid}, 2);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
    endtask

    task automatic t_single(input logic [31:0] a, input logic [3:0] sz, input bit c,
                            input bit st, input bit wb);
        logic [7:0] eb = '0;
        for (int i = 0; i < 8; i++) eb[i] = (i >= int'(a[2:0])) && (i < int'(a[2:0]) + int'(sz));
        issue(a, sz, c, st, wb, 1'b0);
        check(beat_valid && !burst, "R2 single chosen", {beat_valid, burst}, 2);
        check(beat_addr == a, "R8 single address", beat_addr, a);
        check(byte_en == eb, "R8 single lanes", byte_en, eb);
        check(beat_idx == 3'd0, "R3 single index", beat_idx, 0);
        data_ack = 1'b1;
        @(negedge clk);
        data_ack = 1'b0;
        check(done && !beat_valid, "R3 one beat only", {done, beat_valid}, 2);
        @(negedge clk);
    endtask

    task automatic t_fault(input logic [31:0] a, input logic [3:0] sz);
        issue(a, sz, 1'b0, 1'b0, 1'b0, 1'b0);
        check(err && !beat_valid && !done, "R10 reject", {err, beat_valid, done}, 4);
        @(negedge clk);
        check(!err && !beat_valid && !done, "R10 err one cycle", {err, beat_valid, done}, 0);
    endtask

    task automatic t_busy_start;
        logic [31:0] a = 32'h0000_8008;
        issue(a, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        start = 1'b1; start_addr = 32'h0000_4410; narrow_bus = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(beat_valid && beat_addr == a && beat_idx == 3'd0 && byte_en == 8'hFF,
              "R11 start ignored", beat_addr, a);
        for (int i = 0; i < 4; i++) begin
            data_ack = 1'b1;
            @(negedge clk);
        end
        data_ack = 1'b0;
        check(done, "R11 burst completed", done, 1);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst(32'h0000_1234, 1'b0, 1'b0);   // wide, dword 2: 2,3,0,1
        t_burst(32'h0000_5A76, 1'b1, 1'b1);   // narrow store write-back, word 5
        t_burst(32'h0000_0000, 1'b0, 1'b1);   // narrow from word 0
        t_single(32'h0000_2003, 4'd2, 1'b1, 1'b1, 1'b0); // store not write-back
        t_single(32'h0000_3000, 4'd8, 1'b0, 1'b0, 1'b0); // uncached full dword
        t_single(32'h0000_3007, 4'd1, 1'b0, 1'b1, 1'b1); // last byte lane
        t_fault(32'h0000_1006, 4'd4);         // crosses double word
        t_fault(32'h0000_1000, 4'd0);         // zero size
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule